// File: doc/BRIEF.md
# Composite Sync and Colour Burst Shaper

This block sits between a CRT timing controller and the monitor connector. The controller produces a horizontal sync pulse whose width can be programmed from 1 to 16 controller ticks. The block cuts fixed windows out of that pulse, measured in character clocks (LCLKs), and so produces the monitor horizontal sync and the colour burst gate. It also turns the controller vertical sync into a monitor vertical sync three scanlines long. That pulse is aligned to the start of a monitor horizontal sync.

Every window is gated by the controller pulse that is still present. A short controller pulse therefore clips the monitor sync, and it can remove the burst altogether. In 80-column text mode one controller tick is half an LCLK, so a pulse of a given tick count covers half the time. For this reason the block also looks at the controller pulse at the half-LCLK point when that mode is selected. The enable strobes come from a shared divider. One LCLK is 16 pixel clocks and the half strobe sits 8 pixel clocks after the full one.

Top module: `sync_shaper`

## Requirements
- R1: While reset is held, mon_hs, mon_vs and burst_gate are all low.
- R2: The controller hsync is first seen high at an edge with lclk_stb high. After that edge, mon_hs goes high at the edge 2 LCLK strobes later. It stays high for 4 LCLKs, provided the controller pulse lasts long enough. It does not restart while the controller pulse stays high.
- R3: burst_gate goes high at the edge 7 LCLK strobes after that first-high edge and stays high for 2 LCLKs. It never overlaps mon_hs.
- R4: mon_hs and burst_gate both go low at the sampling edge where the controller hsync is first seen low. A controller pulse that ends before an offset gives no window at that offset: no burst for a pulse of 7 LCLKs or less.
- R5: With mode80 = 1, the controller hsync is also sampled at half_stb edges. A deassertion in mid-LCLK ends the outputs at the half-LCLK point.
- R6: With mode80 = 0, half_stb has no effect. A controller hsync that drops in mid-LCLK keeps its outputs running until the next lclk_stb edge.
- R7: The controller vsync is first seen high at an lclk_stb edge. mon_vs then rises on the same edge as the next rising edge of mon_hs. It falls on the same edge as the fourth rising edge of mon_hs after that, so it lasts 3 scanlines.
- R8: A controller hsync shorter than 2 LCLKs produces no mon_hs and no burst_gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lclk_stb | input | 1 | One-cycle strobe at each LCLK boundary |
| half_stb | input | 1 | One-cycle strobe at the middle of each LCLK |
| mode80 | input | 1 | 1 selects 80-column text timing (half-LCLK hsync sampling) |
| ctl_hs | input | 1 | Controller horizontal sync |
| ctl_vs | input | 1 | Controller vertical sync |
| mon_hs | output | 1 | Monitor horizontal sync |
| mon_vs | output | 1 | Monitor vertical sync |
| burst_gate | output | 1 | Colour burst gate |

## Verification
The bench builds the block with its default offsets and widths:
- horizontal sync at 2 + 4 LCLKs,
- burst at 7 + 2 LCLKs,
- a vertical sync of 3 lines.

It drives strobes with a 16-cycle LCLK. These values bring all four controller-pulse cases within reach, 10 and 16 ticks in both 40-column and 80-column mode. Those cases give:
- a full sync,
- a sync clipped to three quarters with no burst,
- a half-length burst.

Odd tick counts and a mid-LCLK drop in 40-column mode exercise the two sampling grids. A series of lines of 10 ticks carries the three-line vertical sync.

// File: rtl/sync_shaper.sv
module sync_shaper #(
  parameter int HS_DLY   = 2,
  parameter int HS_W     = 4,
  parameter int BU_DLY   = 7,
  parameter int BU_W     = 2,
  parameter int VS_LINES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lclk_stb,
  input  logic half_stb,
  input  logic mode80,
  input  logic ctl_hs,
  input  logic ctl_vs,
  output logic mon_hs,
  output logic mon_vs,
  output logic burst_gate
);
  localparam int HS_END  = HS_DLY + HS_W;
  localparam int BU_END  = BU_DLY + BU_W;
  localparam int AGE_MAX = (HS_END > BU_END) ? HS_END : BU_END;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);
  localparam int LN_W    = $clog2(VS_LINES + 1);

  logic             act;
  logic [AGE_W-1:0] age;
  logic             vs_q, vs_pend, vs_on;
  logic [LN_W-1:0]  lines;

  wire hs_begin = lclk_stb && ctl_hs && act && (age == AGE_W'(HS_DLY - 1));
  wire vs_rise  = lclk_stb && ctl_vs && !vs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      age  <= '0;
      vs_q <= 1'b0;
    end else if (lclk_stb) begin
      act  <= ctl_hs;
      vs_q <= ctl_vs;
      if (ctl_hs && act) begin
        if (age != AGE_W'(AGE_MAX)) age <= age + 1'b1;
      end else begin
        age <= '0;
      end
    end else if (half_stb && mode80 && !ctl_hs) begin
      act <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_pend <= 1'b0;
      vs_on   <= 1'b0;
      lines   <= '0;
    end else if (hs_begin) begin
      if (vs_pend || vs_rise) begin
        vs_on   <= 1'b1;
        vs_pend <= 1'b0;
        lines   <= LN_W'(1);
      end else if (vs_on) begin
        if (lines == LN_W'(VS_LINES)) vs_on <= 1'b0;
        else lines <= lines + 1'b1;
      end
    end else if (vs_rise) begin
      vs_pend <= 1'b1;
    end
  end

  assign mon_hs     = act && (age >= AGE_W'(HS_DLY)) && (age < AGE_W'(HS_END));
  assign burst_gate = act && (age >= AGE_W'(BU_DLY)) && (age < AGE_W'(BU_END));
  assign mon_vs     = vs_on;
endmodule

// File: rtl/sync_shaper_chk.sv
module sync_shaper_chk #(
  parameter int HS_W = 4
) (
  input logic clk,
  input logic rst_n,
  input logic lclk_stb,
  input logic mode80,
  input logic mon_hs,
  input logic mon_vs,
  input logic burst_gate
);
  logic [7:0] hs_strobes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_strobes <= '0;
    else if (!mon_hs) hs_strobes <= '0;
    else if (lclk_stb) hs_strobes <= hs_strobes + 1'b1;
  end

  p_hs_rise_on_lclk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mon_hs) |-> $past(lclk_stb));

  p_hs_width_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hs_strobes <= 8'(HS_W));

  p_burst_rise_on_lclk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_gate) |-> $past(lclk_stb));

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mon_hs && burst_gate));

  p_coarse_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode80 && $fell(mon_hs)) |-> $past(lclk_stb));

  p_vs_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mon_vs) |-> $rose(mon_hs));

  p_vs_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mon_vs) |-> $rose(mon_hs));
endmodule

bind sync_shaper sync_shaper_chk #(.HS_W(HS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lclk_stb(lclk_stb), .mode80(mode80),
  .mon_hs(mon_hs), .mon_vs(mon_vs), .burst_gate(burst_gate)
);

// File: tb/sync_shaper_test.sv
`timescale 1ns/1ps
module sync_shaper_test;
  localparam int NL    = 18;
  localparam int LINE  = 1024;
  localparam int HOFF  = 128;
  localparam int VS_ON = 8 * LINE + 512;
  localparam int VS_OF = 10 * LINE + 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lclk_stb = 1'b0, half_stb = 1'b0, mode80 = 1'b0;
  logic ctl_hs = 1'b0, ctl_vs = 1'b0;
  logic mon_hs, mon_vs, burst_gate;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int    dur [NL];
  bit    hi  [NL];
  string tag [NL];

  sync_shaper uut (
    .clk(clk), .rst_n(rst_n), .lclk_stb(lclk_stb), .half_stb(half_stb),
    .mode80(mode80), .ctl_hs(ctl_hs), .ctl_vs(ctl_vs),
    .mon_hs(mon_hs), .mon_vs(mon_vs), .burst_gate(burst_gate)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lidx(int k);
    int l = k / LINE;
    return (l < NL) ? l : NL - 1;
  endfunction

  function automatic int cut(int l);
    int g = hi[l] ? 8 : 16;
    return ((dur[l] + g - 1) / g) * g;
  endfunction

  function automatic bit win(int k, int lo, int hi_end);
    int l = lidx(k);
    int off = k - l * LINE - HOFF;
    int e = (cut(l) < hi_end) ? cut(l) : hi_end;
    return (off >= lo) && (off < e);
  endfunction

  task automatic chk(string t, string nm, bit got, bit exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: got %0b expected %0b", t, nm, cyc, got, exp);
    end
  endtask

  task automatic drive(int n);
    int l = lidx(n);
    int off = n - l * LINE - HOFF;
    rst_n    = (n >= 5);
    lclk_stb = (n % 16 == 0);
    half_stb = (n % 16 == 8);
    mode80   = hi[l];
    ctl_hs   = (off >= 0) && (off < dur[l]);
    ctl_vs   = (n >= VS_ON) && (n < VS_OF);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin dur[i] = 160; hi[i] = 0; tag[i] = "R7"; end
    dur[0] = 160; tag[0] = "R2";
    dur[1] = 256; tag[1] = "R3";
    dur[2] = 80;  hi[2] = 1; tag[2] = "R4";
    dur[3] = 128; hi[3] = 1; tag[3] = "R5";
    dur[4] = 72;  hi[4] = 1; tag[4] = "R5";
    dur[5] = 72;  tag[5] = "R6";
    dur[6] = 16;  tag[6] = "R8";
    dur[7] = 32;  tag[7] = "R8";
    dur[16] = 112; tag[16] = "R4";
    dur[17] = 160; tag[17] = "R2";
    drive(1);
    while (cyc < NL * LINE - 1) begin
      @(negedge clk);
      if (cyc == 2) begin
        chk("R1", "mon_hs", mon_hs, 1'b0);
        chk("R1", "mon_vs", mon_vs, 1'b0);
        chk("R1", "burst_gate", burst_gate, 1'b0);
      end else if (cyc >= 5) begin
        chk(tag[lidx(cyc)], "mon_hs", mon_hs, win(cyc, 32, 96));
        chk(tag[lidx(cyc)], "burst_gate", burst_gate, win(cyc, 112, 144));
        chk("R7", "mon_vs", mon_vs,
            (cyc >= 9 * LINE + HOFF + 32) && (cyc < 12 * LINE + HOFF + 32));
      end
      drive(cyc + 1);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired at cycle %0d: got running expected finished", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule